// File: doc/BRIEF.md
# 256-bit ARX Permutation Core

This block runs a keyless permutation over a 256-bit state. The state is eight 32-bit words arranged as four branches, and each branch pairs an x word with a y word. A caller places the state on `state_in` and the number of steps on `steps_in`, then pulses `start`. The core then applies one full step per clock cycle. When the requested count is reached, it raises `done` for one cycle and leaves the result on `state_out` until the next accepted start. A sponge-style mode of operation can use it as its inner permutation. Loading keys and absorbing messages are handled elsewhere.

Each step has three parts. First, a step-dependent value is injected into the first two y words. Next, four ARX boxes act in parallel, one per branch, each keyed by its own constant. Last, a Feistel-like linear layer folds the left half of the branches into the right half through a 16-bit rotate function and then rotates the branch order. The whole step is combinational, so the only registers are the state word, the step counter, the target count and the controller state.

The controller has three states. `ST_IDLE` waits for a start. `ST_RUN` applies one step per cycle. `ST_DONE` holds for exactly one cycle to flag completion. The transitions are as follows:
- *launch*: from IDLE or DONE to RUN, on a start with a nonzero count.
- *empty*: from IDLE or DONE to DONE, on a start with a zero count.
- *last*: from RUN to DONE, when the step just applied is the final one.
- *retire*: from DONE to IDLE, when no start is present.

Top module: `arx256_perm_core`

## Requirements
- R1: The state word k (k = 0..7) sits in bits [32k+31:32k] of `state_in` and `state_out`. The words are ordered x0, y0, x1, y1, x2, y2, x3, y3, so word 2i is the x word and word 2i+1 is the y word of branch i.
- R2: Constants K0..K7 are B7E15162, BF715880, 38B4DA56, 324E7738, BB1185EB, 4F7C7B57, CFBFA1C8, C2B3293D (hex). At the start of step s (s counted from 0), y0 ^= K[s mod 8] and y1 ^= s, with s zero-extended to 32 bits.
- R3: After the injection, branch i passes through an ARX box keyed by K[i]. Here rotr means rotate right. Each of the four rounds does x += rotr(y,a); y ^= rotr(x,b); x ^= K[i]. The pairs (a,b) in round order are (31,24), (17,17), (0,31), (24,16).
- R4: The linear layer uses f(v) = rotr(v ^ (v << 16), 16), with tx = f(x0^x1) and ty = f(y0^y1). It then forms y2u = y2^tx, y3u = y3^tx, x2u = x2^ty and x3u = x3^ty. The new words are y0' = y3u^y1, y1' = y2u^y0, y2' = y0, y3' = y1, and the x words are built the same way.
- R5: A start with count N ≥ 1 gives a result equal to exactly N steps with s = 0..N-1. `done` is high in the cycle after the N-th rising edge that follows the edge sampling start, and `busy` is high for exactly N cycles before it.
- R6: A start with count 0 returns the input state unchanged, with `done` high in the cycle right after the start edge and `busy` never raised.
- R7: `done` lasts one cycle, and `busy` and `done` are never high together.
- R8: A start while `busy` is high is ignored. The run in progress keeps its state, count and timing.
- R9: Outside a run, `state_out` does not change unless a start is accepted.
- R10: A synchronous active-high `rst` clears `busy`, `done`, the step counter and `state_out` (to zero) at the next edge, including in the middle of a run.
- R11: For counts above 8, the injected constant index wraps modulo 8, while the value XORed into y1 keeps counting (up to 254 with an 8-bit count).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted when not busy |
| steps_in | input | 8 | Number of steps for the run |
| state_in | input | 256 | Initial state, sampled with an accepted start |
| busy | output | 1 | Steps are being applied |
| done | output | 1 | One-cycle completion flag |
| state_out | output | 256 | Current or final state |

## Verification
Random states run with random counts from 0 to 20 against a bench model. This shows whether the ARX rotation pairs, the constant selection per branch and the Feistel rearrangement are right, since a fault in any of them spreads through all eight words. Directed counts test the step-count edges. Count 0 catches a missing bypass, count 1 checks latency, counts 8 and 9 separate a wrapped constant index from a wrapped counter, and count 255 uses the full counter range. An all-zero state shows that the constants alone drive the result. A second start in the middle of a run, with different data, shows whether the run was restarted or its output disturbed. A reset in the middle of a run shows the clearing behaviour.

// File: rtl/arx256_pkg.sv
package arx256_pkg;

    localparam int WORD_W   = 32;
    localparam int ARX_RNDS = 4;
    localparam int NUM_K    = 8;
    localparam int KIDX_W   = $clog2(NUM_K);
    localparam int ELL_SH   = WORD_W / 2;

    typedef logic [WORD_W-1:0] word_t;

    // step constants, indexed by step (mod 8) and by branch
    function automatic word_t kconst(input logic [KIDX_W-1:0] idx);
        word_t k;
        unique case (idx)
            3'd0: k = 32'hB7E15162;
            3'd1: k = 32'hBF715880;
            3'd2: k = 32'h38B4DA56;
            3'd3: k = 32'h324E7738;
            3'd4: k = 32'hBB1185EB;
            3'd5: k = 32'h4F7C7B57;
            3'd6: k = 32'hCFBFA1C8;
            default: k = 32'hC2B3293D;
        endcase
        return k;
    endfunction

    function automatic word_t rotr(input word_t v, input int unsigned r);
        int unsigned rr;
        rr = r % WORD_W;
        if (rr == 0) return v;
        return (v >> rr) | (v << (WORD_W - rr));
    endfunction

    // rotation applied to y before the add in ARX round k
    function automatic int unsigned rot_add(input int k);
        int unsigned r;
        case (k)
            0: r = 31;
            1: r = 17;
            2: r = 0;
            default: r = 24;
        endcase
        return r;
    endfunction

    // rotation applied to x before the xor into y in ARX round k
    function automatic int unsigned rot_xor(input int k);
        int unsigned r;
        case (k)
            0: r = 24;
            1: r = 17;
            2: r = 31;
            default: r = 16;
        endcase
        return r;
    endfunction

    // Feistel mixing function of the linear layer
    function automatic word_t fmix(input word_t v);
        word_t t;
        t = v ^ (v << ELL_SH);
        return rotr(t, ELL_SH);
    endfunction

endpackage

// File: rtl/arx256_box.sv
module arx256_box
    import arx256_pkg::*;
(
    input  word_t x_i,
    input  word_t y_i,
    input  word_t k_i,
    output word_t x_o,
    output word_t y_o
);

    // stage values between rounds, one entry per round boundary
    word_t xs [ARX_RNDS+1];
    word_t ys [ARX_RNDS+1];

    assign xs[0] = x_i;
    assign ys[0] = y_i;

    genvar r;
    generate
        for (r = 0; r < ARX_RNDS; r++) begin : g_rnd
            word_t xa;
            always_comb begin
                xa        = xs[r] + rotr(ys[r], rot_add(r));
                ys[r+1]   = ys[r] ^ rotr(xa, rot_xor(r));
                xs[r+1]   = xa ^ k_i;
            end
        end
    endgenerate

    assign x_o = xs[ARX_RNDS];
    assign y_o = ys[ARX_RNDS];

endmodule

// File: rtl/arx256_mix.sv
module arx256_mix
    import arx256_pkg::*;
#(
    parameter int NUM_BR = 4
) (
    input  word_t [NUM_BR-1:0] xs_i,
    input  word_t [NUM_BR-1:0] ys_i,
    output word_t [NUM_BR-1:0] xs_o,
    output word_t [NUM_BR-1:0] ys_o
);

    localparam int HALF = NUM_BR / 2;

    word_t xacc, yacc, tx, ty;

    always_comb begin
        xacc = '0;
        yacc = '0;
        for (int j = 0; j < HALF; j++) begin
            xacc = xacc ^ xs_i[j];
            yacc = yacc ^ ys_i[j];
        end
        tx = fmix(xacc);
        ty = fmix(yacc);
    end

    genvar j;
    generate
        for (j = 0; j < HALF; j++) begin : g_half
            localparam int SRC_L = (j + 1) % HALF;
            localparam int SRC_R = HALF + SRC_L;
            // left slot takes rotated right branch, updated, plus left branch
            assign xs_o[j]      = xs_i[SRC_R] ^ ty ^ xs_i[SRC_L];
            assign ys_o[j]      = ys_i[SRC_R] ^ tx ^ ys_i[SRC_L];
            // right slot takes the old left branch unchanged
            assign xs_o[j+HALF] = xs_i[j];
            assign ys_o[j+HALF] = ys_i[j];
        end
    endgenerate

endmodule

// File: rtl/arx256_step.sv
module arx256_step
    import arx256_pkg::*;
#(
    parameter int NUM_BR = 4,
    parameter int STEP_W = 8,
    localparam int STATE_W = 2 * NUM_BR * WORD_W
) (
    input  logic [STATE_W-1:0] st_i,
    input  logic [STEP_W-1:0]  idx_i,
    output logic [STATE_W-1:0] st_o
);

    word_t [NUM_BR-1:0] xs_in, ys_in, ys_inj, xs_arx, ys_arx, xs_mix, ys_mix;

    genvar i;
    generate
        for (i = 0; i < NUM_BR; i++) begin : g_unpack
            assign xs_in[i] = st_i[2*WORD_W*i +: WORD_W];
            assign ys_in[i] = st_i[2*WORD_W*i + WORD_W +: WORD_W];
        end
    endgenerate

    // step injection into the first two y words
    always_comb begin
        ys_inj    = ys_in;
        ys_inj[0] = ys_in[0] ^ kconst(idx_i[KIDX_W-1:0]);
        ys_inj[1] = ys_in[1] ^ {{(WORD_W-STEP_W){1'b0}}, idx_i};
    end

    generate
        for (i = 0; i < NUM_BR; i++) begin : g_box
            arx256_box u_box (
                .x_i (xs_in[i]),
                .y_i (ys_inj[i]),
                .k_i (kconst(KIDX_W'(i))),
                .x_o (xs_arx[i]),
                .y_o (ys_arx[i])
            );
        end
    endgenerate

    arx256_mix #(.NUM_BR(NUM_BR)) u_mix (
        .xs_i (xs_arx),
        .ys_i (ys_arx),
        .xs_o (xs_mix),
        .ys_o (ys_mix)
    );

    generate
        for (i = 0; i < NUM_BR; i++) begin : g_pack
            assign st_o[2*WORD_W*i +: WORD_W]          = xs_mix[i];
            assign st_o[2*WORD_W*i + WORD_W +: WORD_W] = ys_mix[i];
        end
    endgenerate

endmodule

// File: rtl/arx256_perm_core.sv
module arx256_perm_core
    import arx256_pkg::*;
#(
    parameter int NUM_BR = 4,
    parameter int STEP_W = 8,
    localparam int STATE_W = 2 * NUM_BR * WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [STEP_W-1:0]  steps_in,
    input  logic [STATE_W-1:0] state_in,
    output logic               busy,
    output logic               done,
    output logic [STATE_W-1:0] state_out
);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_e;

    ctl_e               cur_q, nxt;
    logic [STATE_W-1:0] st_q, st_next;
    logic [STEP_W-1:0]  cnt_q, tgt_q;
    logic               accept, last_step;

    assign accept    = start && (cur_q != ST_RUN);
    assign last_step = (cnt_q == tgt_q - 1'b1);

    arx256_step #(.NUM_BR(NUM_BR), .STEP_W(STEP_W)) u_step (
        .st_i  (st_q),
        .idx_i (cnt_q),
        .st_o  (st_next)
    );

    // controller state register
    always_ff @(posedge clk) begin
        if (rst) cur_q <= ST_IDLE;
        else     cur_q <= nxt;
    end

    // transitions: launch, empty, last, retire
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            ST_IDLE, ST_DONE: begin
                if (start) nxt = (steps_in == '0) ? ST_DONE : ST_RUN;
                else       nxt = ST_IDLE;
            end
            ST_RUN: begin
                if (last_step) nxt = ST_DONE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            cnt_q <= '0;
            tgt_q <= '0;
        end else if (accept) begin
            st_q  <= state_in;
            cnt_q <= '0;
            tgt_q <= steps_in;
        end else if (cur_q == ST_RUN) begin
            st_q  <= st_next;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs decoded from the controller state
    always_comb begin
        busy      = (cur_q == ST_RUN);
        done      = (cur_q == ST_DONE);
        state_out = st_q;
    end

endmodule

// File: rtl/arx256_perm_core_chk.sv
module arx256_perm_core_chk #(
    parameter int STEP_W  = 8,
    parameter int STATE_W = 256
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [STEP_W-1:0]  steps_in,
    input logic               busy,
    input logic               done,
    input logic [STATE_W-1:0] state_out
);

    logic [STEP_W:0]   run_cnt;
    logic [STEP_W-1:0] req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            req_q   <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
            req_q   <= steps_in;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_run_length_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == {1'b0, req_q}));

    assert_launch_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && steps_in != '0) |=> busy);

    assert_zero_count_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && steps_in == '0) |=> (done && !busy));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(state_out));

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (!busy && !done && state_out == '0));

endmodule

bind arx256_perm_core arx256_perm_core_chk #(
    .STEP_W  (STEP_W),
    .STATE_W (STATE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .steps_in  (steps_in),
    .busy      (busy),
    .done      (done),
    .state_out (state_out)
);

// File: tb/arx256_perm_core_bench.sv
module arx256_perm_core_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [7:0]   steps_in = '0;
    logic [255:0] state_in = '0;
    logic         busy, done;
    logic [255:0] state_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    arx256_perm_core u_arx256_perm_core (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .steps_in  (steps_in),
        .state_in  (state_in),
        .busy      (busy),
        .done      (done),
        .state_out (state_out)
    );

    // ---------------- reference model ----------------
    function automatic logic [31:0] rr(input logic [31:0] v, input int r);
        if (r == 0) return v;
        return (v >> r) | (v << (32 - r));
    endfunction

    function automatic logic [31:0] kc(input int i);
        case (i)
            0: return 32'hB7E15162;
            1: return 32'hBF715880;
            2: return 32'h38B4DA56;
            3: return 32'h324E7738;
            4: return 32'hBB1185EB;
            5: return 32'h4F7C7B57;
            6: return 32'hCFBFA1C8;
            default: return 32'hC2B3293D;
        endcase
    endfunction

    function automatic logic [31:0] fm(input logic [31:0] v);
        return rr(v ^ (v << 16), 16);
    endfunction

    function automatic logic [255:0] ref_step(input logic [255:0] s, input int idx);
        logic [31:0] x [4];
        logic [31:0] y [4];
        logic [31:0] c, tx, ty, x2u, x3u, y2u, y3u;
        logic [255:0] o;
        for (int b = 0; b < 4; b++) begin
            x[b] = s[64*b +: 32];
            y[b] = s[64*b+32 +: 32];
        end
        y[0] = y[0] ^ kc(idx % 8);
        y[1] = y[1] ^ 32'(idx);
        for (int b = 0; b < 4; b++) begin
            c = kc(b);
            x[b] = x[b] + rr(y[b], 31); y[b] = y[b] ^ rr(x[b], 24); x[b] = x[b] ^ c;
            x[b] = x[b] + rr(y[b], 17); y[b] = y[b] ^ rr(x[b], 17); x[b] = x[b] ^ c;
            x[b] = x[b] + y[b];         y[b] = y[b] ^ rr(x[b], 31); x[b] = x[b] ^ c;
            x[b] = x[b] + rr(y[b], 24); y[b] = y[b] ^ rr(x[b], 16); x[b] = x[b] ^ c;
        end
        tx = fm(x[0] ^ x[1]);
        ty = fm(y[0] ^ y[1]);
        y2u = y[2] ^ tx; y3u = y[3] ^ tx;
        x2u = x[2] ^ ty; x3u = x[3] ^ ty;
        o[31:0]    = x3u ^ x[1];  o[63:32]   = y3u ^ y[1];
        o[95:64]   = x2u ^ x[0];  o[127:96]  = y2u ^ y[0];
        o[159:128] = x[0];        o[191:160] = y[0];
        o[223:192] = x[1];        o[255:224] = y[1];
        return o;
    endfunction

    function automatic logic [255:0] ref_perm(input logic [255:0] s, input int n);
        logic [255:0] t = s;
        for (int i = 0; i < n; i++) t = ref_step(t, i);
        return t;
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] rnd_state();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    // launch a run and check result, latency, busy, one-cycle done, hold
    task automatic run_one(input string req, input logic [255:0] s, input int n);
        logic [255:0] exp;
        int k;
        int busy_cycles;
        exp = ref_perm(s, n);
        @(negedge clk);
        start = 1'b1; steps_in = 8'(n); state_in = s;
        @(negedge clk);
        start = 1'b0; state_in = rnd_state(); steps_in = 8'($urandom);
        k = 0; busy_cycles = 0;
        while (!done && k < 400) begin
            if (busy) busy_cycles++;
            @(negedge clk);
            k++;
        end
        chk({req, " latency (R5/R6)"}, 256'(k), 256'(n));
        chk({req, " busy cycles R5"}, 256'(busy_cycles), 256'(n));
        chk({req, " result R1"}, state_out, exp);
        chk({req, " busy low at done R7"}, 256'(busy), 256'd0);
        @(negedge clk);
        chk({req, " done one cycle R7"}, 256'(done), 256'd0);
        repeat (3) @(negedge clk);
        chk({req, " held R9"}, state_out, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [255:0] s, exp;
        int k;
        void'($urandom(32'd20250611));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk("reset busy R10", 256'(busy), 256'd0);
        chk("reset done R10", 256'(done), 256'd0);
        chk("reset state R10", state_out, 256'd0);

        // R6: zero count returns input
        s = rnd_state();
        run_one("zero count R6", s, 0);
        // R2/R3/R4: all-zero state, one step
        run_one("zero state one step R2 R3 R4", 256'd0, 1);
        run_one("all ones two steps R4", {256{1'b1}}, 2);
        // R11: constant index wrap
        run_one("eight steps R11", rnd_state(), 8);
        run_one("nine steps R11", rnd_state(), 9);
        run_one("max count R11", rnd_state(), 255);

        // random runs
        for (int it = 0; it < 20; it++) begin
            run_one("random R1 R2 R3 R4 R5", rnd_state(), int'($urandom_range(0, 20)));
        end

        // R8: start while busy is ignored
        s = rnd_state();
        exp = ref_perm(s, 10);
        @(negedge clk);
        start = 1'b1; steps_in = 8'd10; state_in = s;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; steps_in = 8'd1; state_in = rnd_state();
        @(negedge clk);
        start = 1'b0;
        k = 4;
        while (!done && k < 400) begin
            @(negedge clk);
            k++;
        end
        chk("restart ignored latency R8", 256'(k), 256'd10);
        chk("restart ignored result R8", state_out, exp);
        @(negedge clk);
        chk("restart ignored no extra done R8", 256'(done), 256'd0);

        // R9: inputs changing without start leave the output alone
        state_in = rnd_state(); steps_in = 8'd3;
        repeat (4) @(negedge clk);
        chk("no start keeps output R9", state_out, exp);

        // R10: reset mid-run
        @(negedge clk);
        start = 1'b1; steps_in = 8'd50; state_in = rnd_state();
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk("busy before reset R5", 256'(busy), 256'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("mid-run reset busy R10", 256'(busy), 256'd0);
        chk("mid-run reset done R10", 256'(done), 256'd0);
        chk("mid-run reset state R10", state_out, 256'd0);
        // after reset a new run behaves normally
        run_one("after reset R10", rnd_state(), 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule